// File: doc/BRIEF.md
# Power-management interrupt status and mask unit

This block watches the power-state code that a host writes into a peripheral's configuration space. It turns two kinds of change into sticky event flags: a request to enter the deep low-power state (code 2'b11) and a return to the fully-on state (code 2'b00). Each flag sits in a status register that software clears by writing 1 to the bit. A companion enable register selects which flags may drive the single interrupt line.

Software reaches both registers over a simple local register bus. The bus has an address, a write strobe, write data and registered read data. There are two resets. The power-on reset clears everything. The software reset leaves the status and enable registers as they are, so that pending power events survive a firmware restart. The first sampled power-state code after power-on only loads the detector's history. The fully-on code that is present at power-up therefore never shows up as a return event.

Top module: `pm_irq_unit`

## Requirements
- R1: While rst_ni is low and after it rises, the status register, the enable register, irq_o and rdata_o are all 0.
- R2: While sw_rst_ni is low, the status and enable registers keep their contents, and rdata_o is loaded with 0 at each clock edge. After sw_rst_ni rises, reads return the earlier contents.
- R3: A change of pwr_state_i to 2'b11 sets status bit 1 at the next clock edge.
- R4: A change of pwr_state_i from any other code to 2'b00 sets status bit 0 at the next clock edge. A change to 2'b01 or 2'b10, or an unchanged code, sets no status bit.
- R5: The first clock edge after rst_ni rises detects no event, whatever code pwr_state_i holds. The power-up code is only recorded as the starting point.
- R6: A write to offset 0x0 clears each status bit [1:0] whose write-data bit is 1. A status bit whose write-data bit is 0 is left unchanged.
- R7: When an event and a write-1 clear hit the same status bit at the same edge, the bit ends up set.
- R8: Bits 31:2 of both registers always read as 0, and writes to them have no effect.
- R9: A write to offset 0x4 loads enable bits [1:0] from write data [1:0]. A 1 enables the matching source and a 0 disables it.
- R10: irq_o is a register. At each edge it takes the OR over bits 1:0 of (status AND enable), and it stays high until software clears the status bit or the enable bit.
- R11: rdata_o is loaded at the clock edge after the address is presented. Offset 0x0 returns status, offset 0x4 returns the enable register, and any other offset returns 0. The value returned is the register content before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| sw_rst_ni | input | 1 | Software reset, synchronous, active low |
| pwr_state_i | input | 2 | Power-state code from the host configuration register |
| addr_i | input | ADDR_W (4) | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or wrongly set status bit appears in the read data one cycle after an offset-0x0 read. It also drives irq_o one cycle after the status register changes, so a missed or spurious power event is visible within two edges of the code change. A bad history register in the detector shows up either as an event right after power-on or as a missing event on the next real change. The bench checks both ends: directly after reset and after ordinary transitions. A clear that wrongly beats a coincident event leaves a zero status bit, which the bench reads back at once.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned SRC_D0   = 0;
  localparam int unsigned SRC_D3   = 1;
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_MASK = 4;

  typedef enum logic [1:0] {
    PS_ON   = 2'b00,
    PS_LP1  = 2'b01,
    PS_LP2  = 2'b10,
    PS_DEEP = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/pm_evt_detect.sv
module pm_evt_detect
  import pm_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         pwr_state_i,
  output logic [NUM_SRC-1:0] evt_o
);
  logic [1:0] prev_q;
  logic       vld_q;
  logic       chg;

  // first edge after power-on only records the starting code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= PS_ON;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= pwr_state_i;
      vld_q  <= 1'b1;
    end
  end

  assign chg = vld_q && (pwr_state_i != prev_q);

  always_comb begin
    evt_o         = '0;
    evt_o[SRC_D3] = chg && (pwr_state_i == PS_DEEP);
    evt_o[SRC_D0] = chg && (pwr_state_i == PS_ON);
  end
endmodule

// File: rtl/pm_stat_bank.sv
module pm_stat_bank
  import pm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wbits_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(OFS_MASK);

  logic wr_stat, wr_mask;
  assign wr_stat = we_i && (addr_i == STAT_A);
  assign wr_mask = we_i && (addr_i == MASK_A);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic s_q, m_q;
    // set has priority over a coincident write-1 clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= 1'b0;
        m_q <= 1'b0;
      end else begin
        s_q <= evt_i[g] | (s_q & ~(wr_stat & wbits_i[g]));
        if (wr_mask) m_q <= wbits_i[g];
      end
    end
    assign stat_o[g] = s_q;
    assign mask_o[g] = m_q;
  end
endmodule

// File: rtl/pm_rd_port.sv
module pm_rd_port
  import pm_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(OFS_MASK);

  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (addr_i)
      STAT_A:  sel = {{PAD_W{1'b0}}, stat_i};
      MASK_A:  sel = {{PAD_W{1'b0}}, mask_i};
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_o <= '0;
    else if (!sw_rst_ni) rdata_o <= '0;
    else                 rdata_o <= sel;
  end
endmodule

// File: rtl/pm_irq_unit.sv
module pm_irq_unit
  import pm_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_ni,
  input  logic [1:0]        pwr_state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] evt, stat, mask;
  logic               irq_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  pm_evt_detect u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_state_i (pwr_state_i),
    .evt_o       (evt)
  );

  pm_stat_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wbits_i (wdata_i[NUM_SRC-1:0]),
    .evt_i   (evt),
    .stat_o  (stat),
    .mask_o  (mask)
  );

  pm_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_rst_ni (sw_rst_ni),
    .addr_i    (addr_i),
    .stat_i    (stat),
    .mask_i    (mask),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat & mask);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pm_irq_unit_chk.sv
module pm_irq_unit_chk
  import pm_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sw_rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] stat,
  input logic [NUM_SRC-1:0] mask
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r5_no_evt_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> evt == '0);

  a_r3_deep_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[SRC_D3] |=> stat[SRC_D3]);

  a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt[SRC_D0] && we_i && addr_i == ADDR_W'(OFS_STAT) && wdata_i[SRC_D0]) |=> stat[SRC_D0]);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt[SRC_D3] && we_i && addr_i == ADDR_W'(OFS_STAT) && wdata_i[SRC_D3]) |=> !stat[SRC_D3]);

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_SRC] == '0);

  a_r2_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_rst_ni && !we_i && evt == '0) |=> ($stable(stat) && $stable(mask)));

  a_r2_sw_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_rst_ni |=> rdata_o == '0);

  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat & mask) != '0 |=> irq_o);
endmodule

bind pm_irq_unit pm_irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_rst_ni (sw_rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .evt       (evt),
  .stat      (stat),
  .mask      (mask)
);

// File: tb/pm_irq_unit_tb_top.sv
`timescale 1ns/1ps
module pm_irq_unit_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sw_rst_ni = 1'b1;
  logic [1:0]        pwr_state_i = 2'b00;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pm_irq_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (.*);

  typedef struct packed {
    logic [1:0] pwr;
    logic       we;
    logic [3:0] addr;
    logic [3:0] wd;
    logic [1:0] st;
    logic       irq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b1, 4'h4, 4'h3, 2'b00, 1'b0},  // R9 enable both
    '{2'b11, 1'b0, 4'h0, 4'h0, 2'b10, 1'b1},  // R3 R10
    '{2'b11, 1'b1, 4'h0, 4'h2, 2'b00, 1'b0},  // R6 clear bit1
    '{2'b01, 1'b0, 4'h0, 4'h0, 2'b00, 1'b0},  // R4 change to 01: none
    '{2'b00, 1'b0, 4'h0, 4'h0, 2'b01, 1'b1},  // R4 D0 event
    '{2'b00, 1'b1, 4'h0, 4'h0, 2'b01, 1'b1},  // R6 write 0 keeps
    '{2'b00, 1'b1, 4'h4, 4'h2, 2'b01, 1'b0},  // R9 R10 disable bit0
    '{2'b11, 1'b0, 4'h0, 4'h0, 2'b11, 1'b1},  // R3
    '{2'b11, 1'b1, 4'h0, 4'hF, 2'b00, 1'b0},  // R6 clear both
    '{2'b10, 1'b0, 4'h0, 4'h0, 2'b00, 1'b0},  // R4 change to 10: none
    '{2'b00, 1'b1, 4'h0, 4'h1, 2'b01, 1'b0}   // R7 set beats clear
  };

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [DATA_W-1:0] d);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    cyc();
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DATA_W-1:0] d);
    addr_i = a; we_i = 1'b0;
    cyc();
    d = rdata_o;
  endtask

  task automatic por(input logic [1:0] ps);
    rst_ni = 1'b0; pwr_state_i = ps; we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    @(negedge clk_i);
    check("R1 rdata in reset", rdata_o, '0);
    check("R1 irq in reset", {31'b0, irq_o}, '0);
    rst_ni = 1'b1;
    cyc();
    rd(4'h0, d); check("R1 R5 status after power-on", d, '0);
    rd(4'h4, d); check("R1 enable after power-on", d, '0);

    for (int i = 0; i < NV; i++) begin
      pwr_state_i = TBL[i].pwr;
      addr_i = TBL[i].addr; we_i = TBL[i].we; wdata_i = {28'b0, TBL[i].wd};
      cyc();
      we_i = 1'b0; wdata_i = '0; addr_i = 4'h0;
      cyc();
      check($sformatf("R3/R4/R6/R7 vector %0d status", i), rdata_o, {30'b0, TBL[i].st});
      check($sformatf("R10 vector %0d irq", i), {31'b0, irq_o}, {31'b0, TBL[i].irq});
    end

    // R8 upper bits ignored
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R8 R9 enable upper bits", d, 32'h3);
    rd(4'h0, d); check("R8 status upper bits", d, 32'h1);
    check("R10 irq with bit0 enabled", {31'b0, irq_o}, 32'h1);
    // R11 unmapped offset, and read returns pre-write value
    rd(4'h8, d); check("R11 unmapped offset", d, '0);
    wr(4'h0, 32'h1);
    check("R11 read during write sees old value", rdata_o, 32'h1);
    rd(4'h0, d); check("R6 status cleared", d, '0);
    // R2 software reset keeps registers
    pwr_state_i = 2'b11; cyc();
    rd(4'h0, d); check("R2 setup status", d, 32'h2);
    addr_i = 4'h4; sw_rst_ni = 1'b0;
    cyc();
    check("R2 rdata cleared in sw reset", rdata_o, '0);
    cyc();
    sw_rst_ni = 1'b1;
    rd(4'h4, d); check("R2 enable kept", d, 32'h3);
    rd(4'h0, d); check("R2 status kept", d, 32'h2);
    // R1 power-on clears; R5 no event with deep code at power-up
    por(2'b11);
    cyc(); cyc();
    rd(4'h0, d); check("R5 no event from power-up code", d, '0);
    rd(4'h4, d); check("R1 enable cleared", d, '0);
    pwr_state_i = 2'b00; cyc();
    rd(4'h0, d); check("R4 D0 after power-up deep", d, 32'h1);
    check("R10 irq masked", {31'b0, irq_o}, '0);
    // R5 no D0 event when power-up code is 00
    por(2'b00);
    cyc(); cyc();
    rd(4'h0, d); check("R5 no D0 event at power-on", d, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule